// File: doc/BRIEF.md
# Vector-Banked Register File

This block is the architectural register store of a small vector-capable core. A 7-bit register id picks one of 128 locations. Ids 0 to 111 hold general registers. Each general register is 32 bits wide and is banked into `LANES` copies, one per vector lane. Ids 112 to 127 map, in order, onto sixteen system slots numbered 0 to 15.

Two read ports and two write ports serve instruction formats with two sources or two destinations. One lane index input is shared by all four ports. It picks the lane that general-register reads return and that general-register writes update.

Three system slots are protected:
- Slot 0 always reads zero.
- Slot 1 mirrors the program counter supplied from outside.
- Slot 2 reports the lane count as a constant.

A write to any of these three is accepted and consumes its cycle, but it changes nothing. Slots 3, 4 and 5 hold vector control state. Slots 6 to 15 are reserved.

Top module: `vreg_bank`

## Requirements
- R1: Ids 0–111 address general registers. Id 112+k addresses system slot k, for k = 0..15. Writing general id 111 must not affect the value read at id 112.
- R2: A write to a general id stores the data in the lane given by `lane_i` only. The new value is visible on the read ports from the next cycle, and the other lanes of that register keep their contents.
- R3: Id 112 (zero slot) always reads 0, and a write to it has no effect.
- R4: Id 113 (program counter slot) reads the current value of `pc_i`, and a write to it has no effect.
- R5: Id 114 (depth slot) reads the constant `LANES` (a power of two, at most 32), and a write to it has no effect.
- R6: Ids 115 and 117 are writable 32-bit registers. Id 116 is a writable lane mask that keeps only bits [LANES-1:0] of the written data and reads with all higher bits zero.
- R7: Reads are combinational. The two read ports are independent and can return different ids in the same cycle.
- R8: Ids 118–127 read as 0 and ignore writes.
- R9: When both write ports are enabled for the same id in one cycle, the data of port 0 is stored.
- R10: Reset (`rst_n` low, synchronous) clears every lane of every general register and the writable system slots 115–117 to 0.
- R11: Two enabled writes to different ids in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_i | input | 32 | Address of the current instruction, returned at id 113 |
| lane_i | input | LANE_W | Vector lane selected for all reads and writes of general ids |
| ra0 | input | 7 | Read port 0 id |
| rd0 | output | 32 | Read port 0 data |
| ra1 | input | 7 | Read port 1 id |
| rd1 | output | 32 | Read port 1 data |
| we0 | input | 1 | Write port 0 enable |
| wa0 | input | 7 | Write port 0 id |
| wd0 | input | 32 | Write port 0 data |
| we1 | input | 1 | Write port 1 enable |
| wa1 | input | 7 | Write port 1 id |
| wd1 | input | 32 | Write port 1 data |

## Verification
The bench aims at these corner cases:
- The boundary between id 111 and id 112. A wrong id decoder would alias the last general register onto the zero slot.
- Writes aimed at the three protected slots and the reserved range. A design that lets them through would read the written data back instead of zero, `pc_i` or the lane count.
- Two write ports colliding on one id. Wrong priority would store port 1's data.
- Writes to one lane of a register. A banking error would change neighbouring lanes or return the wrong lane on reads.
- The mask slot. Without truncation, stray high bits would show on reads.

// File: rtl/vreg_bank.sv
module vreg_bank #(
  parameter int LANES  = 4,
  parameter int XLEN   = 32,
  parameter int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [6:0]        ra0,
  output logic [XLEN-1:0]   rd0,
  input  logic [6:0]        ra1,
  output logic [XLEN-1:0]   rd1,
  input  logic              we0,
  input  logic [6:0]        wa0,
  input  logic [XLEN-1:0]   wd0,
  input  logic              we1,
  input  logic [6:0]        wa1,
  input  logic [XLEN-1:0]   wd1
);
  localparam int NGPR = 112;
  localparam logic [6:0] ID_VLEN = 7'd115;
  localparam logic [6:0] ID_MASK = 7'd116;
  localparam logic [6:0] ID_VIDX = 7'd117;

  logic [XLEN-1:0]  gpr [NGPR][LANES];
  logic [XLEN-1:0]  vlen, vidx;
  logic [LANES-1:0] vmask;

  function automatic logic [XLEN-1:0] fetch(input logic [6:0] a);
    if (a < 7'(NGPR)) return gpr[a][lane_i];
    case (a[3:0])
      4'd1:    return pc_i;
      4'd2:    return XLEN'(LANES);
      4'd3:    return vlen;
      4'd4:    return XLEN'(vmask);
      4'd5:    return vidx;
      default: return '0;
    endcase
  endfunction

  always_comb rd0 = fetch(ra0);
  always_comb rd1 = fetch(ra1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NGPR; i++)
        for (int l = 0; l < LANES; l++)
          gpr[i][l] <= '0;
      vlen  <= '0;
      vmask <= '0;
      vidx  <= '0;
    end else begin
      // port 1 first so that port 0 overrides it on a shared id
      if (we1) begin
        if (wa1 < 7'(NGPR)) gpr[wa1][lane_i] <= wd1;
        if (wa1 == ID_VLEN) vlen  <= wd1;
        if (wa1 == ID_MASK) vmask <= wd1[LANES-1:0];
        if (wa1 == ID_VIDX) vidx  <= wd1;
      end
      if (we0) begin
        if (wa0 < 7'(NGPR)) gpr[wa0][lane_i] <= wd0;
        if (wa0 == ID_VLEN) vlen  <= wd0;
        if (wa0 == ID_MASK) vmask <= wd0[LANES-1:0];
        if (wa0 == ID_VIDX) vidx  <= wd0;
      end
    end
  end
endmodule

// File: rtl/vreg_bank_chk.sv
module vreg_bank_chk #(
  parameter int LANES  = 4,
  parameter int XLEN   = 32,
  parameter int LANE_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [XLEN-1:0]   pc_i,
  input logic [LANE_W-1:0] lane_i,
  input logic [6:0]        ra0,
  input logic [XLEN-1:0]   rd0,
  input logic [6:0]        ra1,
  input logic [XLEN-1:0]   rd1,
  input logic              we0,
  input logic [6:0]        wa0,
  input logic [XLEN-1:0]   wd0
);
  AST_ZERO_SLOT: assert property (@(posedge clk) disable iff (!rst_n) (ra0 == 7'd112) |-> (rd0 == '0)); // R3
  AST_PC_SLOT: assert property (@(posedge clk) disable iff (!rst_n) (ra1 == 7'd113) |-> (rd1 == pc_i)); // R4
  AST_DEPTH_SLOT: assert property (@(posedge clk) disable iff (!rst_n) (ra0 == 7'd114) |-> (rd0 == XLEN'(LANES))); // R5
  AST_MASK_HIGH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (ra1 == 7'd116) |-> ((64'(rd1) >> LANES) == 64'd0)); // R6
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (ra0 >= 7'd118) |-> (rd0 == '0)); // R8
  AST_PORT0_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(we0) && ($past(wa0) < 7'd112) && (ra1 == $past(wa0)) && (lane_i == $past(lane_i)))
      |-> (rd1 == $past(wd0))); // R9
endmodule

bind vreg_bank vreg_bank_chk #(.LANES(LANES), .XLEN(XLEN), .LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .lane_i(lane_i),
  .ra0(ra0), .rd0(rd0), .ra1(ra1), .rd1(rd1),
  .we0(we0), .wa0(wa0), .wd0(wd0)
);

// File: tb/vreg_bank_bench.sv
`timescale 1ns/1ps
module vreg_bank_bench;
  localparam int LANES = 4;
  localparam int LW = 2;

  logic clk = 0, rst_n = 0;
  logic [31:0] pc_i = 0;
  logic [LW-1:0] lane_i = 0;
  logic [6:0] ra0 = 0, ra1 = 0, wa0 = 0, wa1 = 0;
  logic [31:0] wd0 = 0, wd1 = 0, rd0, rd1;
  logic we0 = 0, we1 = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] mg [112][LANES];
  logic [31:0] mvlen, mmask, mvidx;

  always #4 clk = ~clk;

  vreg_bank #(.LANES(LANES)) u_vreg_bank (
    .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .lane_i(lane_i),
    .ra0(ra0), .rd0(rd0), .ra1(ra1), .rd1(rd1),
    .we0(we0), .wa0(wa0), .wd0(wd0), .we1(we1), .wa1(wa1), .wd1(wd1));

  function automatic logic [31:0] mread(int id, int lane);
    if (id < 112) return mg[id][lane];
    case (id - 112)
      1: return pc_i;
      2: return 32'(LANES);
      3: return mvlen;
      4: return mmask;
      5: return mvidx;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(int id);
    if (id < 112) return "R2";
    if (id == 112) return "R3";
    if (id == 113) return "R4";
    if (id == 114) return "R5";
    if (id <= 117) return "R6";
    return "R8";
  endfunction

  task automatic mwrite(int id, int lane, logic [31:0] d);
    if (id < 112) mg[id][lane] = d;
    else if (id == 115) mvlen = d;
    else if (id == 116) mmask = 32'((64'(d)) & ((64'd1 << LANES) - 64'd1));
    else if (id == 117) mvidx = d;
  endtask

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Drive one cycle: apply at negedge, compare reads, then advance the model at the edge.
  task automatic cyc(string tag, int r0, int r1, int ln,
                     bit e0, int a0, logic [31:0] d0,
                     bit e1, int a1, logic [31:0] d1);
    ra0 = 7'(r0); ra1 = 7'(r1); lane_i = LW'(ln);
    we0 = e0; wa0 = 7'(a0); wd0 = d0;
    we1 = e1; wa1 = 7'(a1); wd1 = d1;
    #1;
    check((tag == "") ? tag_of(r0) : tag, rd0, mread(r0, ln));
    check((tag == "") ? tag_of(r1) : tag, rd1, mread(r1, ln));
    @(posedge clk);
    if (rst_n) begin
      if (e1) mwrite(a1, ln, d1);
      if (e0) mwrite(a0, ln, d0);
    end
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 112; i++)
      for (int l = 0; l < LANES; l++) mg[i][l] = 0;
    mvlen = 0; mmask = 0; mvidx = 0;
    pc_i = 32'h0000_1000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R10: everything cleared by reset
    for (int id = 0; id < 128; id++)
      cyc((id < 112 || (id >= 115 && id <= 117)) ? "R10" : "", id, 127 - id, id % LANES, 0, 0, 0, 0, 0, 0);

    // R2: single-lane write, other lanes untouched
    cyc("R2", 5, 5, 2, 1, 5, 32'hCAFE_0005, 0, 0, 0);
    for (int l = 0; l < LANES; l++) cyc("R2", 5, 6, l, 0, 0, 0, 0, 0, 0);

    // R1: last general id versus the zero slot
    cyc("R1", 111, 112, 1, 1, 111, 32'hA5A5_006F, 0, 0, 0);
    cyc("R1", 111, 112, 1, 0, 0, 0, 0, 0, 0);

    // R3, R4, R5, R8: writes to protected and reserved ids have no effect
    cyc("R3", 112, 112, 0, 1, 112, 32'hFFFF_FFFF, 1, 113, 32'h1234_5678);
    pc_i = 32'h0000_2468;
    cyc("R4", 113, 112, 0, 1, 114, 32'h0000_0099, 1, 120, 32'hDEAD_BEEF);
    cyc("R5", 114, 113, 0, 1, 127, 32'h0BAD_F00D, 1, 118, 32'h1111_1111);
    cyc("R8", 120, 127, 0, 0, 0, 0, 0, 0, 0);
    cyc("R8", 118, 118, 0, 0, 0, 0, 0, 0, 0);

    // R6: vector control slots and mask truncation
    cyc("R6", 115, 116, 0, 1, 115, 32'h0000_0003, 1, 116, 32'hFFFF_FFFA);
    cyc("R6", 115, 116, 0, 1, 117, 32'h0000_0002, 0, 0, 0);
    cyc("R6", 117, 116, 3, 0, 0, 0, 0, 0, 0);

    // R9: collision, port 0 wins
    cyc("R9", 7, 7, 1, 1, 7, 32'h0000_AAAA, 1, 7, 32'h0000_BBBB);
    cyc("R9", 7, 7, 1, 1, 116, 32'h0000_0001, 1, 116, 32'h0000_000E);
    cyc("R9", 7, 116, 1, 0, 0, 0, 0, 0, 0);

    // R11: two different destinations in one cycle
    cyc("R11", 9, 10, 3, 1, 9, 32'h9999_0009, 1, 10, 32'h1010_000A);
    cyc("R11", 9, 10, 3, 0, 0, 0, 0, 0, 0);

    // R7: independent combinational reads
    cyc("R7", 5, 113, 2, 0, 0, 0, 0, 0, 0);
    pc_i = 32'h0000_3000;
    cyc("R7", 113, 9, 3, 0, 0, 0, 0, 0, 0);

    // Random traffic against the reference model
    for (int n = 0; n < 4000; n++) begin
      int r0, r1, a0, a1;
      r0 = ($urandom % 4 == 0) ? 112 + $urandom % 16 : $urandom % 12;
      r1 = ($urandom % 4 == 0) ? 112 + $urandom % 16 : $urandom % 12;
      a0 = ($urandom % 4 == 0) ? 112 + $urandom % 16 : $urandom % 12;
      a1 = ($urandom % 3 == 0) ? a0 : (($urandom % 4 == 0) ? 112 + $urandom % 16 : $urandom % 12);
      if (n % 50 == 0) pc_i = $urandom;
      cyc("", r0, r1, $urandom % LANES, 1'($urandom), a0, $urandom, 1'($urandom), a1, $urandom);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule